// File: doc/BRIEF.md
# Dual-Mode L2 Hash Bucket Lookup

This block is the station table of an Ethernet switch: it remembers which port each unicast MAC address was last seen on, separately per VLAN. A request carries a 48-bit MAC, a 12-bit VLAN ID, a source port and a static flag. The block forms a 60-bit seed with the VLAN ID above the MAC and folds it into a 12-bit hash with one of two XOR-fold functions, chosen by a mode input. The low `BKT_W` bits of that hash select a bucket of four ways. All four ways are read and compared in the same cycle. The response is registered one cycle after the request is accepted.

A lookup reports a hit and the stored port and flags. A learn request also refreshes a matching dynamic entry, or places a new entry in the lowest free way of the bucket. When every way is taken it raises a bucket-full flag. A host port reads and writes single entries by bucket and way. A host access takes priority over requests in the cycle it is made.

Top module: `l2_hash_table`

## Requirements
- R1: With `hash_mode`=1, `rsp_hash` is the seed S={4'b0, vid, mac} folded as follows. The upper 6 bits are the XOR of the 6-bit fields of S starting at bits 6, 12, 30, 36, 54 and 60, where bits above 63 read as zero. The lower 6 bits are the XOR of the fields starting at bits 0, 18, 24, 42 and 48.
- R2: With `hash_mode`=0, `rsp_hash` is the XOR of five terms: S[63:60]; {S[53:48], S[59:54]}; and the 12-bit fields S[11:0], S[23:12], S[35:24] and S[47:36].
- R3: The bucket used for a request is `rsp_hash[BKT_W-1:0]`. The host port addresses the same storage by bucket and way, so an entry learned through a request can be read back at that bucket and at `rsp_slot`.
- R4: The response (`rsp_valid`) appears exactly one cycle after `req_valid && req_ready` and at no other time. A hit needs both the MAC and the VLAN ID to match a valid entry. On a hit, `rsp_slot`, `rsp_port` and the flags report that entry as it was before the request.
- R5: An entry is valid only if at least one of its port, static, block-source, block-destination, suspended or age fields is nonzero. An entry with all of these zero is free and never hits, whatever MAC it holds.
- R6: A learn request that misses writes the lowest-numbered free way with the request's MAC, VLAN ID, port and static flag, with age 3 and with the block and suspended flags clear. It reports `rsp_learned`=1 and that way on `rsp_slot`.
- R7: A learn request that misses in a bucket with no free way raises `rsp_full`, leaves the table unchanged, and reports neither a hit nor a learn.
- R8: A learn request that hits a non-static entry sets that entry's port to the request's port and its age to 3. All other fields are kept, and it reports `rsp_learned`=1.
- R9: A learn request that hits a static entry changes nothing and reports `rsp_learned`=0.
- R10: A MAC with bit 40 set (the least significant bit of the first octet, a group address) is never learned. Such a learn request reports `rsp_learned`=0 and `rsp_full`=0.
- R11: While `host_en` is 1, `req_ready` is 0 and requests are not taken. A host read (`host_we`=0) returns the entry on `host_rdata` with `host_rvalid`=1 one cycle later. A host write stores `host_wdata` at once.
- R12: A request with `req_learn`=0 never modifies the table and never reports `rsp_learned` or `rsp_full`.
- R13: The entry layout, LSB first, is: age[1:0], suspended[2], block-destination[3], block-source[4], static[5], port[6 +: PORT_W], then the VLAN ID (12 bits), then the MAC (48 bits) at the top. With the defaults this is 72 bits. After reset, `rsp_valid` and `host_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hash_mode | input | 1 | 1 selects the split 6+6 fold, 0 the 12-bit fold |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_learn | input | 1 | 1 = learn, 0 = lookup only |
| req_mac | input | 48 | MAC address |
| req_vid | input | 12 | VLAN ID |
| req_port | input | PORT_W | Source port for learning |
| req_static | input | 1 | Static flag for a new entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | MAC and VLAN matched a valid entry |
| rsp_learned | output | 1 | Table written by this request |
| rsp_full | output | 1 | Learn missed and the bucket had no free way |
| rsp_slot | output | SLOT_W | Way that hit or was written |
| rsp_hash | output | 12 | Hash of the request |
| rsp_port | output | PORT_W | Stored port of the hit entry |
| rsp_static | output | 1 | Static flag of the hit entry |
| rsp_blk_sa | output | 1 | Block-source flag of the hit entry |
| rsp_blk_da | output | 1 | Block-destination flag of the hit entry |
| rsp_susp | output | 1 | Suspended flag of the hit entry |
| rsp_age | output | 2 | Age of the hit entry |
| host_en | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_bucket | input | BKT_W | Bucket index |
| host_slot | input | SLOT_W | Way within the bucket |
| host_wdata | input | ENTRY_W | Entry to write |
| host_rvalid | output | 1 | Read data present |
| host_rdata | output | ENTRY_W | Entry read |

## Verification
The hardest case to reach from the ports is a bucket with all four ways taken, because the bucket index depends on the hash of the address. The bench evaluates the hash formula itself and scans address candidates until it finds five that fall in one bucket. It learns four of them to fill the bucket, and the fifth then exercises the full case. The free-but-matching entry is also hard to reach, because learning never creates one. The bench plants it through the host port, as an entry with a known MAC and every flag field zero.

// File: rtl/l2ht_pkg.sv
package l2ht_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int HASH_W = 12;
  localparam int AGE_W  = 2;
  localparam int FLAG_W = 4;
  localparam logic [AGE_W-1:0] AGE_FRESH = 2'd3;
  // bit of the MAC that marks a group address (lsb of the first octet)
  localparam int MC_BIT = MAC_W - 8;

  typedef enum logic {
    FOLD_TWELVE = 1'b0,
    FOLD_SPLIT  = 1'b1
  } fold_mode_e;
endpackage

// File: rtl/l2ht_hash.sv
module l2ht_hash
  import l2ht_pkg::*;
(
  input  logic              mode,
  input  logic [MAC_W-1:0]  mac,
  input  logic [VID_W-1:0]  vid,
  output logic [HASH_W-1:0] hash
);
  localparam int PAD_W = 72;

  logic [PAD_W-1:0]  s;
  logic [5:0]        hi6, lo6;
  logic [HASH_W-1:0] wide;

  assign s = {{(PAD_W-MAC_W-VID_W){1'b0}}, vid, mac};

  always_comb begin
    hi6  = s[65:60] ^ s[59:54] ^ s[41:36] ^ s[35:30] ^ s[17:12] ^ s[11:6];
    lo6  = s[53:48] ^ s[47:42] ^ s[29:24] ^ s[23:18] ^ s[5:0];
    wide = {8'h00, s[63:60]} ^ {s[53:48], s[59:54]}
         ^ s[47:36] ^ s[35:24] ^ s[23:12] ^ s[11:0];
  end

  assign hash = (fold_mode_e'(mode) == FOLD_SPLIT) ? {hi6, lo6} : wide;
endmodule

// File: rtl/l2ht_way_mem.sv
module l2ht_way_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 72,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/l2ht_match.sv
module l2ht_match
  import l2ht_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int PORT_W  = 6,
  localparam int SLOT_W  = $clog2(WAYS),
  localparam int VID_LSB = AGE_W + FLAG_W + PORT_W,
  localparam int MAC_LSB = VID_LSB + VID_W,
  localparam int ENTRY_W = MAC_LSB + MAC_W
) (
  input  logic [WAYS-1:0][ENTRY_W-1:0] ways,
  input  logic [MAC_W-1:0]             key_mac,
  input  logic [VID_W-1:0]             key_vid,
  output logic                         hit,
  output logic [SLOT_W-1:0]            hit_idx,
  output logic                         has_free,
  output logic [SLOT_W-1:0]            free_idx
);
  logic [WAYS-1:0] live, match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign live[w]  = |ways[w][VID_LSB-1:0];
    assign match[w] = live[w]
                    && (ways[w][MAC_LSB +: MAC_W] == key_mac)
                    && (ways[w][VID_LSB +: VID_W] == key_vid);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(w);
      end
      if (!live[w]) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(w);
      end
    end
  end
endmodule

// File: rtl/l2_hash_table.sv
module l2_hash_table
  import l2ht_pkg::*;
#(
  parameter int BKT_W  = 8,
  parameter int WAYS   = 4,
  parameter int PORT_W = 6,
  localparam int SLOT_W   = $clog2(WAYS),
  localparam int PORT_LSB = AGE_W + FLAG_W,
  localparam int VID_LSB  = PORT_LSB + PORT_W,
  localparam int MAC_LSB  = VID_LSB + VID_W,
  localparam int ENTRY_W  = MAC_LSB + MAC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hash_mode,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_learn,
  input  logic [MAC_W-1:0]    req_mac,
  input  logic [VID_W-1:0]    req_vid,
  input  logic [PORT_W-1:0]   req_port,
  input  logic                req_static,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_learned,
  output logic                rsp_full,
  output logic [SLOT_W-1:0]   rsp_slot,
  output logic [HASH_W-1:0]   rsp_hash,
  output logic [PORT_W-1:0]   rsp_port,
  output logic                rsp_static,
  output logic                rsp_blk_sa,
  output logic                rsp_blk_da,
  output logic                rsp_susp,
  output logic [AGE_W-1:0]    rsp_age,
  input  logic                host_en,
  input  logic                host_we,
  input  logic [BKT_W-1:0]    host_bucket,
  input  logic [SLOT_W-1:0]   host_slot,
  input  logic [ENTRY_W-1:0]  host_wdata,
  output logic                host_rvalid,
  output logic [ENTRY_W-1:0]  host_rdata
);
  localparam int SUSP_B = AGE_W;
  localparam int BDA_B  = AGE_W + 1;
  localparam int BSA_B  = AGE_W + 2;
  localparam int STAT_B = AGE_W + 3;

  logic [HASH_W-1:0]            hash;
  logic [BKT_W-1:0]             bkt;
  logic [WAYS-1:0][ENTRY_W-1:0] way_rd;
  logic [WAYS-1:0][ENTRY_W-1:0] way_wd;
  logic [WAYS-1:0]              way_we;
  logic                         hit, has_free;
  logic [SLOT_W-1:0]            hit_idx, free_idx;
  logic [ENTRY_W-1:0]           hit_e, upd_e, new_e;
  logic                         fire, learn_ok, do_upd, do_ins, do_full;

  l2ht_hash u_hash (
    .mode (hash_mode),
    .mac  (req_mac),
    .vid  (req_vid),
    .hash (hash)
  );

  assign req_ready = ~host_en;
  assign fire      = req_valid & req_ready;
  assign bkt       = host_en ? host_bucket : hash[BKT_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    l2ht_way_mem #(.ADDR_W(BKT_W), .DATA_W(ENTRY_W)) u_mem (
      .clk   (clk),
      .we    (way_we[w]),
      .addr  (bkt),
      .wdata (way_wd[w]),
      .rdata (way_rd[w])
    );
  end

  l2ht_match #(.WAYS(WAYS), .PORT_W(PORT_W)) u_match (
    .ways     (way_rd),
    .key_mac  (req_mac),
    .key_vid  (req_vid),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  always_comb begin
    hit_e    = way_rd[hit_idx];
    learn_ok = fire & req_learn & ~req_mac[MC_BIT];
    do_upd   = learn_ok & hit & ~hit_e[STAT_B];
    do_ins   = learn_ok & ~hit & has_free;
    do_full  = learn_ok & ~hit & ~has_free;

    upd_e = hit_e;
    upd_e[PORT_LSB +: PORT_W] = req_port;
    upd_e[AGE_W-1:0]          = AGE_FRESH;

    new_e = {req_mac, req_vid, req_port, req_static, 3'b000, AGE_FRESH};

    for (int w = 0; w < WAYS; w++) begin
      if (host_en) begin
        way_we[w] = host_we && (host_slot == SLOT_W'(w));
        way_wd[w] = host_wdata;
      end else if (do_upd && hit_idx == SLOT_W'(w)) begin
        way_we[w] = 1'b1;
        way_wd[w] = upd_e;
      end else begin
        way_we[w] = do_ins && (free_idx == SLOT_W'(w));
        way_wd[w] = new_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_learned <= 1'b0;
      rsp_full    <= 1'b0;
      rsp_slot    <= '0;
      rsp_hash    <= '0;
      rsp_port    <= '0;
      rsp_static  <= 1'b0;
      rsp_blk_sa  <= 1'b0;
      rsp_blk_da  <= 1'b0;
      rsp_susp    <= 1'b0;
      rsp_age     <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      rsp_valid   <= fire;
      rsp_hit     <= fire & hit;
      rsp_learned <= do_upd | do_ins;
      rsp_full    <= do_full;
      rsp_slot    <= hit ? hit_idx : (has_free ? free_idx : '0);
      rsp_hash    <= hash;
      rsp_port    <= hit ? hit_e[PORT_LSB +: PORT_W] : '0;
      rsp_static  <= hit & hit_e[STAT_B];
      rsp_blk_sa  <= hit & hit_e[BSA_B];
      rsp_blk_da  <= hit & hit_e[BDA_B];
      rsp_susp    <= hit & hit_e[SUSP_B];
      rsp_age     <= hit ? hit_e[AGE_W-1:0] : '0;
      host_rvalid <= host_en & ~host_we;
      if (host_en && !host_we) host_rdata <= way_rd[host_slot];
    end
  end
endmodule

// File: rtl/l2ht_checks.sv
module l2ht_checks
  import l2ht_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_learn,
  input logic [MAC_W-1:0] req_mac,
  input logic             host_en,
  input logic             host_we,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_learned,
  input logic             rsp_full,
  input logic             host_rvalid
);
  // R4
  rsp_follows_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  // R4
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R7
  full_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_full |-> (rsp_valid && !rsp_hit && !rsp_learned));
  // R10
  group_no_learn_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mac[MC_BIT]) |=> (!rsp_learned && !rsp_full));
  // R12
  lookup_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_learn) |=> (!rsp_learned && !rsp_full));
  // R11
  host_read_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (host_en && !host_we) |=> host_rvalid);
  // R11
  host_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_en && !host_we) |=> !host_rvalid);
endmodule

bind l2_hash_table l2ht_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_learn   (req_learn),
  .req_mac     (req_mac),
  .host_en     (host_en),
  .host_we     (host_we),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_learned (rsp_learned),
  .rsp_full    (rsp_full),
  .host_rvalid (host_rvalid)
);

// File: tb/tb_l2_hash_table.sv
module tb_l2_hash_table;
  localparam int CLK_PERIOD = 10;
  localparam int BKT_W   = 4;
  localparam int WAYS    = 4;
  localparam int PORT_W  = 6;
  localparam int SLOT_W  = 2;
  localparam int ENTRY_W = 72;
  localparam int NBKT    = 1 << BKT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hash_mode = 1'b0;
  logic req_valid = 1'b0, req_learn = 1'b0, req_static = 1'b0;
  logic [47:0] req_mac = '0;
  logic [11:0] req_vid = '0;
  logic [PORT_W-1:0] req_port = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_learned, rsp_full;
  logic [SLOT_W-1:0] rsp_slot;
  logic [11:0] rsp_hash;
  logic [PORT_W-1:0] rsp_port;
  logic rsp_static, rsp_blk_sa, rsp_blk_da, rsp_susp;
  logic [1:0] rsp_age;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [BKT_W-1:0] host_bucket = '0;
  logic [SLOT_W-1:0] host_slot = '0;
  logic [ENTRY_W-1:0] host_wdata = '0;
  logic host_rvalid;
  logic [ENTRY_W-1:0] host_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_hash_table #(.BKT_W(BKT_W), .WAYS(WAYS), .PORT_W(PORT_W)) dut (
    .clk(clk), .rst(rst), .hash_mode(hash_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_learn(req_learn),
    .req_mac(req_mac), .req_vid(req_vid), .req_port(req_port),
    .req_static(req_static),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_learned(rsp_learned),
    .rsp_full(rsp_full), .rsp_slot(rsp_slot), .rsp_hash(rsp_hash),
    .rsp_port(rsp_port), .rsp_static(rsp_static), .rsp_blk_sa(rsp_blk_sa),
    .rsp_blk_da(rsp_blk_da), .rsp_susp(rsp_susp), .rsp_age(rsp_age),
    .host_en(host_en), .host_we(host_we), .host_bucket(host_bucket),
    .host_slot(host_slot), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input logic [ENTRY_W-1:0] act,
                     input logic [ENTRY_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_hash(input bit m, input logic [47:0] mac,
                                           input logic [11:0] vid);
    logic [63:0] s;
    logic [63:0] a, b, h;
    s = {4'h0, vid, mac};
    if (m) begin
      a = ((s >> 60) & 63) ^ ((s >> 54) & 63) ^ ((s >> 36) & 63)
        ^ ((s >> 30) & 63) ^ ((s >> 12) & 63) ^ ((s >> 6) & 63);
      b = ((s >> 48) & 63) ^ ((s >> 42) & 63) ^ ((s >> 24) & 63)
        ^ ((s >> 18) & 63) ^ (s & 63);
      h = (a << 6) | b;
    end else begin
      h = (s >> 60) ^ ((((s >> 48) & 63) << 6) | ((s >> 54) & 63))
        ^ ((s >> 36) & 64'hfff) ^ ((s >> 24) & 64'hfff)
        ^ ((s >> 12) & 64'hfff) ^ (s & 64'hfff);
    end
    return h[11:0];
  endfunction

  // R13 layout
  function automatic logic [ENTRY_W-1:0] mk(input logic [47:0] mac, input logic [11:0] vid,
      input logic [PORT_W-1:0] port, input bit st, input bit bsa, input bit bda,
      input bit su, input logic [1:0] age);
    return {mac, vid, port, st, bsa, bda, su, age};
  endfunction

  task automatic do_req(input bit learn, input logic [47:0] mac, input logic [11:0] vid,
                        input logic [PORT_W-1:0] port, input bit st);
    @(negedge clk);
    req_valid = 1'b1; req_learn = learn; req_mac = mac; req_vid = vid;
    req_port = port; req_static = st;
    @(posedge clk); #1;
    @(negedge clk);
    req_valid = 1'b0; req_learn = 1'b0;
  endtask

  task automatic hwrite(input logic [BKT_W-1:0] b, input logic [SLOT_W-1:0] s,
                        input logic [ENTRY_W-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_bucket = b; host_slot = s; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [BKT_W-1:0] b, input logic [SLOT_W-1:0] s,
                       output logic [ENTRY_W-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_bucket = b; host_slot = s;
    @(posedge clk); #1;
    d = host_rdata;
    chk("R11 host_rvalid", ENTRY_W'(host_rvalid), ENTRY_W'(1));
    @(negedge clk);
    host_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] cand [5];
    logic [47:0] mN, mQ, mR, m;
    logic [ENTRY_W-1:0] rd;
    logic [BKT_W-1:0] b, bN, bR;
    logic [63:0] x;
    int n;

    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 rsp_valid reset", ENTRY_W'(rsp_valid), ENTRY_W'(0));
    chk("R13 host_rvalid reset", ENTRY_W'(host_rvalid), ENTRY_W'(0));
    chk("R11 ready idle", ENTRY_W'(req_ready), ENTRY_W'(1));

    for (int i = 0; i < NBKT; i++)
      for (int s = 0; s < WAYS; s++)
        hwrite(BKT_W'(i), SLOT_W'(s), '0);

    // R1 R2: walking one over all seed bits, both folds
    for (int md = 0; md < 2; md++) begin
      hash_mode = md[0];
      for (int k = 0; k < 60; k++) begin
        logic [59:0] sd;
        sd = 60'd1 << k;
        do_req(1'b0, sd[47:0], sd[59:48], '0, 1'b0);
        chk(md ? "R1 hash walk" : "R2 hash walk", ENTRY_W'(rsp_hash),
            ENTRY_W'(ref_hash(md[0], sd[47:0], sd[59:48])));
        chk("R12 no learn on lookup", ENTRY_W'({rsp_learned, rsp_full, rsp_hit}), '0);
      end
    end
    // R1 R2: pseudo-random seeds
    x = 64'h9e3779b97f4a7c15;
    for (int k = 0; k < 120; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      hash_mode = x[63];
      do_req(1'b0, x[47:0], x[59:48], '0, 1'b0);
      chk(x[63] ? "R1 hash rand" : "R2 hash rand", ENTRY_W'(rsp_hash),
          ENTRY_W'(ref_hash(x[63], x[47:0], x[59:48])));
    end

    // find five unicast addresses sharing one bucket (fold 0, vid 5)
    hash_mode = 1'b0;
    b = ref_hash(1'b0, 48'h0200_0000_0000, 12'd5) % NBKT;
    n = 0;
    for (int k = 0; k < 4000 && n < 5; k++) begin
      m = 48'h0200_0000_0000 + 48'(k) * 48'h101;
      if ((ref_hash(1'b0, m, 12'd5) % NBKT) == b) begin
        cand[n] = m; n++;
      end
    end

    // R6: fill four ways in order
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, cand[i], 12'd5, PORT_W'(i + 1), 1'b0);
      chk("R6 learned", ENTRY_W'({rsp_learned, rsp_hit, rsp_full}), ENTRY_W'(3'b100));
      chk("R6 slot", ENTRY_W'(rsp_slot), ENTRY_W'(i));
    end
    for (int i = 0; i < 4; i++) begin
      hread(b, SLOT_W'(i), rd);
      chk("R3 R6 stored entry", rd, mk(cand[i], 12'd5, PORT_W'(i + 1), 0, 0, 0, 0, 2'd3));
    end

    // R7: bucket full
    do_req(1'b1, cand[4], 12'd5, 6'd9, 1'b0);
    chk("R7 full flag", ENTRY_W'({rsp_full, rsp_learned, rsp_hit}), ENTRY_W'(3'b100));
    for (int i = 0; i < 4; i++) begin
      hread(b, SLOT_W'(i), rd);
      chk("R7 table unchanged", rd, mk(cand[i], 12'd5, PORT_W'(i + 1), 0, 0, 0, 0, 2'd3));
    end
    do_req(1'b0, cand[4], 12'd5, '0, 1'b0);
    chk("R7 rejected not stored", ENTRY_W'(rsp_hit), ENTRY_W'(0));

    // R4: hit fields, vid mismatch
    do_req(1'b0, cand[2], 12'd5, '0, 1'b0);
    chk("R4 hit", ENTRY_W'({rsp_valid, rsp_hit, rsp_slot, rsp_port, rsp_age}),
        ENTRY_W'({1'b1, 1'b1, 2'd2, 6'd3, 2'd3}));
    do_req(1'b0, cand[2], 12'd6, '0, 1'b0);
    chk("R4 vid mismatch misses", ENTRY_W'(rsp_hit), ENTRY_W'(0));

    // R8: refresh dynamic entry
    hwrite(b, 2'd1, mk(cand[1], 12'd5, 6'd2, 0, 1, 0, 1, 2'd1));
    do_req(1'b1, cand[1], 12'd5, 6'd9, 1'b0);
    chk("R8 hit report old", ENTRY_W'({rsp_hit, rsp_learned, rsp_port, rsp_blk_sa, rsp_susp, rsp_age}),
        ENTRY_W'({1'b1, 1'b1, 6'd2, 1'b1, 1'b1, 2'd1}));
    hread(b, 2'd1, rd);
    chk("R8 refreshed", rd, mk(cand[1], 12'd5, 6'd9, 0, 1, 0, 1, 2'd3));

    // R9: static entry untouched
    hwrite(b, 2'd0, mk(cand[0], 12'd5, 6'd7, 1, 0, 1, 0, 2'd0));
    do_req(1'b1, cand[0], 12'd5, 6'd5, 1'b0);
    chk("R9 static hit", ENTRY_W'({rsp_hit, rsp_learned, rsp_static, rsp_blk_da, rsp_port}),
        ENTRY_W'({1'b1, 1'b0, 1'b1, 1'b1, 6'd7}));
    hread(b, 2'd0, rd);
    chk("R9 static unchanged", rd, mk(cand[0], 12'd5, 6'd7, 1, 0, 1, 0, 2'd0));

    // R5: all-zero flags means free
    hwrite(b, 2'd3, mk(cand[3], 12'd5, 6'd0, 0, 0, 0, 0, 2'd0));
    do_req(1'b0, cand[3], 12'd5, '0, 1'b0);
    chk("R5 free entry misses", ENTRY_W'(rsp_hit), ENTRY_W'(0));
    do_req(1'b1, cand[4], 12'd5, 6'd6, 1'b0);
    chk("R5 free way reused", ENTRY_W'({rsp_learned, rsp_slot}), ENTRY_W'({1'b1, 2'd3}));
    hread(b, 2'd3, rd);
    chk("R5 R6 new entry", rd, mk(cand[4], 12'd5, 6'd6, 0, 0, 0, 0, 2'd3));

    // R10: group address never learned
    do_req(1'b1, 48'h0100_5e00_0001, 12'd5, 6'd4, 1'b0);
    chk("R10 group learn", ENTRY_W'({rsp_learned, rsp_full, rsp_hit}), ENTRY_W'(0));
    do_req(1'b0, 48'h0100_5e00_0001, 12'd5, '0, 1'b0);
    chk("R10 group absent", ENTRY_W'(rsp_hit), ENTRY_W'(0));

    // addresses in other buckets
    mN = '0; mQ = '0; n = 0;
    for (int k = 5000; k < 9000 && n < 2; k++) begin
      m = 48'h0200_0000_0000 + 48'(k) * 48'h101;
      if ((ref_hash(1'b0, m, 12'd5) % NBKT) != b) begin
        if (n == 0) mN = m; else mQ = m;
        n++;
      end
    end
    bN = ref_hash(1'b0, mN, 12'd5) % NBKT;

    // R12: lookup does not insert
    do_req(1'b0, mN, 12'd5, 6'd1, 1'b0);
    chk("R12 lookup miss", ENTRY_W'({rsp_hit, rsp_learned}), ENTRY_W'(0));
    do_req(1'b0, mN, 12'd5, 6'd1, 1'b0);
    chk("R12 still absent", ENTRY_W'(rsp_hit), ENTRY_W'(0));
    do_req(1'b1, mN, 12'd5, 6'd1, 1'b1);
    do_req(1'b0, mN, 12'd5, '0, 1'b0);
    chk("R6 static learned hit", ENTRY_W'({rsp_hit, rsp_static, rsp_port}),
        ENTRY_W'({1'b1, 1'b1, 6'd1}));

    // R11: host takes priority
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_bucket = b; host_slot = 2'd2;
    req_valid = 1'b1; req_learn = 1'b1; req_mac = mQ; req_vid = 12'd5; req_port = 6'd3;
    #1;
    chk("R11 ready low", ENTRY_W'(req_ready), ENTRY_W'(0));
    @(posedge clk); #1;
    chk("R11 no response", ENTRY_W'(rsp_valid), ENTRY_W'(0));
    chk("R11 read data", host_rdata, mk(cand[2], 12'd5, 6'd3, 0, 0, 0, 0, 2'd3));
    @(negedge clk);
    host_en = 1'b0; req_valid = 1'b0; req_learn = 1'b0;
    do_req(1'b0, mQ, 12'd5, '0, 1'b0);
    chk("R11 blocked learn dropped", ENTRY_W'(rsp_hit), ENTRY_W'(0));

    // R3: split fold places entry in its bucket
    hash_mode = 1'b1;
    mR = '0;
    for (int k = 100; k < 4000; k++) begin
      m = 48'h0600_0000_0000 + 48'(k) * 48'h10001;
      if ((ref_hash(1'b1, m, 12'd7) % NBKT) != b &&
          (ref_hash(1'b1, m, 12'd7) % NBKT) != bN) begin
        mR = m; break;
      end
    end
    bR = ref_hash(1'b1, mR, 12'd7) % NBKT;
    do_req(1'b1, mR, 12'd7, 6'd2, 1'b0);
    chk("R3 hash", ENTRY_W'(rsp_hash), ENTRY_W'(ref_hash(1'b1, mR, 12'd7)));
    chk("R3 learned slot0", ENTRY_W'({rsp_learned, rsp_slot}), ENTRY_W'({1'b1, 2'd0}));
    hread(bR, 2'd0, rd);
    chk("R3 readback", rd, mk(mR, 12'd7, 6'd2, 0, 0, 0, 0, 2'd3));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule